// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host-facing pins of a parallel NOR flash device and turns bus write cycles into device commands. It watches the chip-enable, write-enable and output-enable levels, takes the address at the start of each write cycle and the data at its end, and walks the multi-cycle unlock protocol. The result is a set of one-clock strobes for the embedded-algorithm engine: reset, autoselect entry, program (with the latched address and data), chip erase, sector erase (with the sector index), erase suspend and erase resume.

While in identification mode the block also answers reads with the manufacturer code, a parameterised device code, a continuation code and a per-sector protection flag. It handles both 8-bit and 16-bit bus configurations, and the unlock addresses change with the configuration. The engine tells the decoder when an embedded operation is running. At that time the decoder drops every write except a suspend aimed at a running sector erase. All bus inputs are assumed to be synchronous to `clk`. Sectors are uniform, and the sector index is the top bits of the word address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write cycle exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. A command takes effect when that condition ends. Its strobe is high for exactly one clock, on the first clock edge after the condition ends. At most one strobe is high in any cycle.
- R2: The address is the one on `bus_addr` at the first clock of the write cycle. The data is the value on `bus_wdata` at the last clock of the write cycle.
- R3: The unlock pair is AAh then 55h in the low data byte. In word mode (`byte_mode`=0) the addresses are 555h then 2AAh, compared on `bus_addr[10:0]`. In byte mode they are AAAh then 555h, compared on `bus_addr[11:0]`.
- R4: A third write at the first unlock address after the unlock pair does the following: 90h enters identification mode and pulses `do_autosel`; A0h arms a program; 80h arms an erase.
- R5: Once a program is armed, the next write of any value pulses `do_program`, with `prog_addr` and `prog_data` (all 16 bits) taken from that write. The decoder then returns to read mode.
- R6: An armed erase needs the unlock pair again. After it, 10h at the first unlock address pulses `do_chip_erase`, and 30h at any address pulses `do_sector_erase`. The sector index is the top 4 bits of the word address. The word address is `bus_addr[18:0]` in word mode and `bus_addr[19:1]` in byte mode.
- R7: A wrong address or data value at any step returns the decoder to read mode with no strobe.
- R8: F0h at any address pulses `do_reset` and returns to read mode, from every state except the armed-program data write. In that write, F0h is programmed as data.
- R9: In identification mode `id_data` depends on the low 8 bits of the word address: 00h gives 37h, 01h gives `DEV_CODE`, 02h gives 01h if `prot_map[sector]` is set and 00h otherwise, 03h gives 7Fh, and any other offset gives 00h. Outside identification mode `id_data` is 00h. `id_mode` shows the mode.
- R10: Only F0h leaves identification mode. Any other write leaves it in place and produces no strobe.
- R11: While `eng_busy`=1 every write is ignored, with one exception. B0h pulses `do_suspend` when `eng_sect_erase`=1.
- R12: In read mode, 30h pulses `do_resume` only if a suspend has been accepted and not yet resumed. B0h or 30h written in any other case has no effect.
- R13: After reset the decoder is in read mode, every strobe is low, `id_mode`=0 and `id_data`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_mode | input | 1 | 1 = 8-bit bus addressing, 0 = 16-bit |
| bus_addr | input | 20 | Bus address (byte address in byte mode) |
| bus_wdata | input | 16 | Bus write data |
| eng_busy | input | 1 | Embedded operation running |
| eng_sect_erase | input | 1 | Running operation is a sector erase |
| prot_map | input | 16 | Protection flag per sector |
| do_reset | output | 1 | Reset command strobe |
| do_autosel | output | 1 | Identification entry strobe |
| do_program | output | 1 | Program strobe |
| prog_addr | output | 20 | Program address |
| prog_data | output | 16 | Program data |
| do_chip_erase | output | 1 | Chip erase strobe |
| do_sector_erase | output | 1 | Sector erase strobe |
| erase_sector | output | 4 | Sector index for sector erase |
| do_suspend | output | 1 | Erase suspend strobe |
| do_resume | output | 1 | Erase resume strobe |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read data |

## Verification
The assertions assume that bus inputs change only between clock edges. They also assume that `eng_sect_erase` is meaningful only while `eng_busy` is high, and that the address is held for the length of a write cycle unless a test deliberately moves it. The stimulus drives every pin on the falling clock edge. It builds each write as at least two active clocks followed by an idle clock, so that captures and completions never share an edge. The engine inputs are changed only between write cycles.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        S_READ, S_UL1, S_UL2, S_PROG, S_ER1, S_ER2, S_ER3, S_ID
    } seq_e;

    typedef struct packed {
        logic resm;
        logic susp;
        logic sect;
        logic chip;
        logic prog;
        logic asel;
        logic rst;
    } strobe_t;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECT    = 8'h30;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] ID_MFR      = 8'h37;
    localparam logic [7:0] ID_CONT     = 8'h7F;

    // second = 0 checks the first unlock address, 1 the second
    function automatic logic unlock_hit(input logic bm, input logic [11:0] a,
                                        input logic second);
        if (bm)
            return second ? (a == 12'h555) : (a == 12'hAAA);
        return second ? (a[10:0] == 11'h2AA) : (a[10:0] == 11'h555);
    endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              commit
);
    logic wr_now, wr_prev;

    assign wr_now = ~ce_n & ~we_n & oe_n;
    assign commit = wr_prev & ~wr_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now && !wr_prev) addr_q <= addr;   // later falling edge
            if (wr_now)             data_q <= wdata;  // last active clock
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        wr_prev && wr_now |=> $stable(addr_q)); // R2
    AST_DATA_LAST: assert property (@(posedge clk) disable iff (rst)
        commit |-> data_q == $past(wdata)); // R2
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              byte_mode,
    input  logic              eng_busy,
    input  logic              eng_sect_erase,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    output strobe_t           stb,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic [SECT_W-1:0] erase_sector,
    output logic              id_mode
);
    seq_e        st, st_n;
    strobe_t     stb_n;
    logic        susp_q, susp_n;
    logic [7:0]  cmd;
    logic        hit1, hit2;
    logic [SECT_W-1:0] sect_of;

    assign cmd     = data_q[7:0];
    assign hit1    = unlock_hit(byte_mode, addr_q[11:0], 1'b0);
    assign hit2    = unlock_hit(byte_mode, addr_q[11:0], 1'b1);
    assign sect_of = byte_mode ? addr_q[ADDR_W-1 -: SECT_W] : addr_q[ADDR_W-2 -: SECT_W];
    assign id_mode = (st == S_ID);

    always_comb begin
        st_n   = st;
        stb_n  = '0;
        susp_n = susp_q;
        if (commit) begin
            if (eng_busy) begin
                if (cmd == CMD_SUSPEND && eng_sect_erase) begin
                    stb_n.susp = 1'b1;
                    susp_n     = 1'b1;
                end
            end else if (st != S_PROG && cmd == CMD_RESET) begin
                st_n      = S_READ;
                stb_n.rst = 1'b1;
            end else begin
                case (st)
                    S_READ: begin
                        if (cmd == CMD_KEY_A && hit1) st_n = S_UL1;
                        else if (cmd == CMD_RESUME && susp_q) begin
                            stb_n.resm = 1'b1;
                            susp_n     = 1'b0;
                        end
                    end
                    S_UL1: st_n = (cmd == CMD_KEY_B && hit2) ? S_UL2 : S_READ;
                    S_UL2: begin
                        st_n = S_READ;
                        if (hit1) begin
                            if (cmd == CMD_AUTOSEL) begin
                                st_n       = S_ID;
                                stb_n.asel = 1'b1;
                            end else if (cmd == CMD_PROG)  st_n = S_PROG;
                            else if (cmd == CMD_ERASE)     st_n = S_ER1;
                        end
                    end
                    S_PROG: begin
                        stb_n.prog = 1'b1;
                        st_n       = S_READ;
                    end
                    S_ER1: st_n = (cmd == CMD_KEY_A && hit1) ? S_ER2 : S_READ;
                    S_ER2: st_n = (cmd == CMD_KEY_B && hit2) ? S_ER3 : S_READ;
                    S_ER3: begin
                        st_n = S_READ;
                        if (cmd == CMD_CHIP && hit1) stb_n.chip = 1'b1;
                        else if (cmd == CMD_SECT)    stb_n.sect = 1'b1;
                    end
                    S_ID:    st_n = S_ID;
                    default: st_n = S_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_READ;
            susp_q       <= 1'b0;
            stb          <= '0;
            prog_addr    <= '0;
            prog_data    <= '0;
            erase_sector <= '0;
        end else begin
            st     <= st_n;
            susp_q <= susp_n;
            stb    <= stb_n;
            if (stb_n.prog) begin
                prog_addr <= addr_q;
                prog_data <= data_q;
            end
            if (stb_n.sect) erase_sector <= sect_of;
        end
    end

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        commit && eng_busy |=> !(stb.rst || stb.asel || stb.prog || stb.chip || stb.sect || stb.resm)); // R11
    AST_SUSP_GATED: assert property (@(posedge clk) disable iff (rst)
        stb.susp |-> $past(eng_busy && eng_sect_erase)); // R11
    AST_RESUME_AFTER_SUSP: assert property (@(posedge clk) disable iff (rst)
        stb.resm |-> $past(susp_q) && !susp_q); // R12
    AST_ID_STICKY: assert property (@(posedge clk) disable iff (rst)
        st == S_ID && !(commit && !eng_busy && cmd == CMD_RESET) |=> st == S_ID); // R10
    AST_PROG_FROM_SETUP: assert property (@(posedge clk) disable iff (rst)
        stb.prog |-> $past(st) == S_PROG); // R5
endmodule

// File: rtl/fcd_idrom.sv
module fcd_idrom
    import fcd_pkg::*;
#(
    parameter int       NUM_SECT = 16,
    parameter int       SECT_W   = 4,
    parameter logic [7:0] DEV_CODE = 8'h5A
) (
    input  logic                id_mode,
    input  logic [7:0]          offset,
    input  logic [SECT_W-1:0]   sect,
    input  logic [NUM_SECT-1:0] prot_map,
    output logic [7:0]          id_data
);
    always_comb begin
        id_data = 8'h00;
        if (id_mode) begin
            case (offset)
                8'h00:   id_data = ID_MFR;
                8'h01:   id_data = DEV_CODE;
                8'h02:   id_data = {7'd0, prot_map[sect]};
                8'h03:   id_data = ID_CONT;
                default: id_data = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         DATA_W   = 16,
    parameter int         NUM_SECT = 16,
    parameter logic [7:0] DEV_CODE = 8'h5A,
    localparam int        SECT_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                eng_busy,
    input  logic                eng_sect_erase,
    input  logic [NUM_SECT-1:0] prot_map,
    output logic                do_reset,
    output logic                do_autosel,
    output logic                do_program,
    output logic [ADDR_W-1:0]   prog_addr,
    output logic [DATA_W-1:0]   prog_data,
    output logic                do_chip_erase,
    output logic                do_sector_erase,
    output logic [SECT_W-1:0]   erase_sector,
    output logic                do_suspend,
    output logic                do_resume,
    output logic                id_mode,
    output logic [7:0]          id_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              commit;
    strobe_t           stb;
    logic [7:0]        id_off;
    logic [SECT_W-1:0] id_sect;

    fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(bus_addr), .wdata(bus_wdata),
        .addr_q(addr_q), .data_q(data_q), .commit(commit));

    fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_seq (
        .clk(clk), .rst(rst), .commit(commit), .byte_mode(byte_mode),
        .eng_busy(eng_busy), .eng_sect_erase(eng_sect_erase),
        .addr_q(addr_q), .data_q(data_q), .stb(stb),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_sector(erase_sector), .id_mode(id_mode));

    // word-address view of the live bus address for identification reads
    assign id_off  = byte_mode ? bus_addr[8:1] : bus_addr[7:0];
    assign id_sect = byte_mode ? bus_addr[ADDR_W-1 -: SECT_W] : bus_addr[ADDR_W-2 -: SECT_W];

    fcd_idrom #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode(id_mode), .offset(id_off), .sect(id_sect),
        .prot_map(prot_map), .id_data(id_data));

    assign do_reset        = stb.rst;
    assign do_autosel      = stb.asel;
    assign do_program      = stb.prog;
    assign do_chip_erase   = stb.chip;
    assign do_sector_erase = stb.sect;
    assign do_suspend      = stb.susp;
    assign do_resume       = stb.resm;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({do_reset, do_autosel, do_program, do_chip_erase,
                  do_sector_erase, do_suspend, do_resume})); // R1
    AST_ID_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !id_mode |-> id_data == 8'h00); // R9
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        ce_n = 1, we_n = 1, oe_n = 1, bm = 0;
    logic [19:0] addr = '0;
    logic [15:0] wd = '0;
    logic        busy = 0, serase = 0;
    logic [15:0] prot = 16'h0204;

    logic        do_reset, do_autosel, do_program, do_chip_erase, do_sector_erase;
    logic        do_suspend, do_resume, id_mode;
    logic [19:0] prog_addr;
    logic [15:0] prog_data;
    logic [3:0]  erase_sector;
    logic [7:0]  id_data;

    flash_cmd_decoder uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_mode(bm), .bus_addr(addr), .bus_wdata(wd),
        .eng_busy(busy), .eng_sect_erase(serase), .prot_map(prot),
        .do_reset(do_reset), .do_autosel(do_autosel), .do_program(do_program),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .do_chip_erase(do_chip_erase), .do_sector_erase(do_sector_erase),
        .erase_sector(erase_sector), .do_suspend(do_suspend),
        .do_resume(do_resume), .id_mode(id_mode), .id_data(id_data));

    always #10 clk = ~clk;

    int    vecs = 0, errs = 0;
    string cur_req = "R13";
    bit    mon_on = 0;

    // reference model state
    int          mstep = 0;
    bit          msusp = 0, midm = 0;
    bit          armed = 0;
    logic [6:0]  pend = '0;      // {resume,suspend,sector,chip,program,autosel,reset}
    logic [19:0] pend_pa;
    logic [15:0] pend_pd;
    logic [3:0]  pend_sect;

    function automatic logic [7:0] exp_id(input bit idm, input logic [19:0] a,
                                          input logic b, input logic [15:0] pm);
        int w;
        w = b ? int'(a >> 1) : int'(a & 20'h7FFFF);
        if (!idm) return 8'h00;
        case (w % 256)
            0: return 8'h37;
            1: return 8'h5A;
            2: return pm[w / 32768] ? 8'h01 : 8'h00;
            3: return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model(input logic [19:0] a, input logic [15:0] d);
        logic [7:0] c;
        bit u1, u2;
        int w;
        c  = d[7:0];
        u1 = bm ? (a[11:0] == 12'hAAA) : (a[10:0] == 11'h555);
        u2 = bm ? (a[11:0] == 12'h555) : (a[10:0] == 11'h2AA);
        w  = bm ? int'(a >> 1) : int'(a & 20'h7FFFF);
        pend = '0;
        if (busy) begin
            if (c == 8'hB0 && serase) begin pend[5] = 1; msusp = 1; end
            return;
        end
        if (mstep != 3 && c == 8'hF0) begin pend[0] = 1; mstep = 0; midm = 0; return; end
        if (midm) return;
        case (mstep)
            0: if (c == 8'hAA && u1) mstep = 1;
               else if (c == 8'h30 && msusp) begin pend[6] = 1; msusp = 0; end
            1: mstep = (c == 8'h55 && u2) ? 2 : 0;
            2: begin
                mstep = 0;
                if (u1 && c == 8'h90) begin midm = 1; pend[1] = 1; end
                else if (u1 && c == 8'hA0) mstep = 3;
                else if (u1 && c == 8'h80) mstep = 4;
            end
            3: begin pend[2] = 1; pend_pa = a; pend_pd = d; mstep = 0; end
            4: mstep = (c == 8'hAA && u1) ? 5 : 0;
            5: mstep = (c == 8'h55 && u2) ? 6 : 0;
            6: begin
                mstep = 0;
                if (c == 8'h10 && u1) pend[3] = 1;
                else if (c == 8'h30) begin pend[4] = 1; pend_sect = 4'(w / 32768); end
            end
            default: mstep = 0;
        endcase
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        logic [6:0] cur, got;
        if (mon_on) begin
            cur   = armed ? pend : 7'd0;
            armed = 0;
            #5;
            got = {do_resume, do_suspend, do_sector_erase, do_chip_erase,
                   do_program, do_autosel, do_reset};
            vecs++;
            if (got !== cur) begin
                errs++;
                $display("FAIL %s strobes got %b exp %b", cur_req, got, cur);
            end
            if (cur[2]) begin
                vecs++;
                if (prog_addr !== pend_pa || prog_data !== pend_pd) begin
                    errs++;
                    $display("FAIL %s program payload got %h/%h exp %h/%h",
                             cur_req, prog_addr, prog_data, pend_pa, pend_pd);
                end
            end
            if (cur[4]) begin
                vecs++;
                if (erase_sector !== pend_sect) begin
                    errs++;
                    $display("FAIL %s sector got %0d exp %0d", cur_req, erase_sector, pend_sect);
                end
            end
            vecs++;
            if (id_mode !== midm || id_data !== exp_id(midm, addr, bm, prot)) begin
                errs++;
                $display("FAIL %s id got %b/%h exp %b/%h", cur_req, id_mode, id_data,
                         midm, exp_id(midm, addr, bm, prot));
            end
        end
    end

    // kind 0: valid write; 1: output enable low; 2: chip enable high
    task automatic wr2(input logic [19:0] a1, input logic [19:0] a2,
                       input logic [15:0] d1, input logic [15:0] d2, input int kind);
        @(negedge clk);
        addr = a1; wd = d1;
        ce_n = (kind == 2); we_n = 0; oe_n = (kind != 1);
        @(negedge clk);
        addr = a2; wd = d2;
        @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
        if (kind == 0) begin model(a1, d2); armed = 1; end
        @(negedge clk);
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        wr2(a, a, d, d, 0);
    endtask

    task automatic unlock();
        wr(bm ? 20'hAAA : 20'h555, 16'h00AA);
        wr(bm ? 20'h555 : 20'h2AA, 16'h0055);
    endtask

    task automatic peek(input logic [19:0] a);
        @(negedge clk); addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [19:0] u1;
        repeat (2) @(negedge clk);
        mon_on = 1;                      // R13: reset state checked while reset held
        repeat (2) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);

        cur_req = "R5";                  // word-mode program, R3 addresses
        unlock(); wr(20'h555, 16'h00A0); wr(20'h12345, 16'hBEEF);
        cur_req = "R2";                  // address from first clock, data from last
        unlock(); wr(20'h555, 16'h00A0); wr2(20'h0ABCD, 20'h70001, 16'h1111, 16'h2222, 0);
        cur_req = "R8";                  // F0h as program data is programmed
        unlock(); wr(20'h555, 16'h00A0); wr(20'h00040, 16'h00F0);

        cur_req = "R3";                  // byte mode
        bm = 1;
        unlock(); wr(20'hAAA, 16'h00A0); wr(20'hF0F0F, 16'h00C3);
        cur_req = "R7";                  // word addresses rejected in byte mode
        wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h0055); wr(20'h555, 16'h00A0); wr(20'h00100, 16'h1234);
        cur_req = "R6";                  // byte-mode sector erase, sector 9
        unlock(); wr(20'hAAA, 16'h0080); unlock(); wr(20'h90000, 16'h0030);
        bm = 0;

        cur_req = "R7";                  // wrong data in the second unlock write
        wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h0054); wr(20'h555, 16'h00A0); wr(20'h00100, 16'h1234);
        cur_req = "R7";                  // chip erase code at the wrong address
        unlock(); wr(20'h555, 16'h0080); unlock(); wr(20'h00123, 16'h0010);
        cur_req = "R6";
        unlock(); wr(20'h555, 16'h0080); unlock(); wr(20'h555, 16'h0010);
        unlock(); wr(20'h555, 16'h0080); unlock(); wr(20'hC8000, 16'h0030);

        cur_req = "R8";                  // reset mid-sequence kills the erase
        unlock(); wr(20'h555, 16'h0080); wr(20'h555, 16'h00AA); wr(20'h3FFFF, 16'h00F0);
        wr(20'h2AA, 16'h0055); wr(20'h555, 16'h0010);

        cur_req = "R4";                  // identification mode, word reads
        unlock(); wr(20'h555, 16'h0090);
        cur_req = "R9";
        peek(20'h00000); peek(20'h00001); peek(20'h48002); peek(20'h18002);
        peek(20'h00003); peek(20'h00004); peek(20'h10002);
        bm = 1;
        peek(20'h00002); peek(20'h00006); peek(20'h90004); peek(20'h00001);
        bm = 0;
        cur_req = "R10";
        unlock(); wr(20'h555, 16'h00A0); wr(20'h00010, 16'h5555); peek(20'h00000);
        wr(20'h00000, 16'h00F0); peek(20'h00001);

        cur_req = "R11";                 // engine busy with a program
        busy = 1; serase = 0;
        unlock(); wr(20'h555, 16'h00A0); wr(20'h00020, 16'h9999);
        wr(20'h00000, 16'h00B0); wr(20'h00000, 16'h00F0);
        serase = 1;
        wr(20'h12000, 16'h00F0); wr(20'h12000, 16'h00B0);
        busy = 0; serase = 0;
        cur_req = "R12";
        wr(20'h00000, 16'h00B0); wr(20'h0777, 16'h0030); wr(20'h0777, 16'h0030);

        cur_req = "R1";                  // writes with bad control levels
        wr2(20'h00000, 20'h00000, 16'h00F0, 16'h00F0, 1);
        wr2(20'h00000, 20'h00000, 16'h00F0, 16'h00F0, 2);
        u1 = 20'h555;
        wr2(u1, u1, 16'h00AA, 16'h00AA, 1);
        wr(20'h2AA, 16'h0055); wr(20'h555, 16'h0090);
        repeat (3) @(negedge clk);

        mon_on = 0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule